// File: doc/BRIEF.md
# Dual Down-Counter Snapshot and Preload Port

This block puts a byte-wide register port in front of two free-running down-counters. Counter 0 is 24 bits wide and counter 1 is 16 bits wide. Each counter counts down by one on every clock cycle where its own enable input is high. On reaching zero it wraps to all ones. Its value changes in only one other way: a preload command.

Software first writes preload data into three shared staging bytes. It then writes a command byte. The command picks a counter and either preloads that counter from the staging bytes or snapshots its current count into a latch register for that counter. The staging bytes cannot be read back. Reads of the three data locations return bytes of the most recent snapshot. The upper data location always returns the top byte of counter 0's snapshot. Every access is qualified by a page select, and this page responds only when the page select is low.

Top module: `dual_cnt_snap`

## Requirements
- R1: After reset, every staging byte, both counters and both snapshot registers are zero, so reads of offsets 12, 13 and 14 return 0x00.
- R2: A write to offset 12, 13 or 14 changes only a staging byte. It changes no counter value, and a following read of that offset does not return the written byte.
- R3: A write to offset 15 is a command. Bit 0 selects the counter (0 = counter 0, 1 = counter 1). Bits 2:1 are the opcode: 01 = preload, 10 = snapshot, 00 and 11 = no operation, which changes no counter and no snapshot.
- R4: A preload of counter 0 loads the value {offset 14 byte, offset 13 byte, offset 12 byte} on the clock edge that accepts the command.
- R5: A preload of counter 1 loads {offset 13 byte, offset 12 byte}. The offset 14 byte has no effect on it.
- R6: A snapshot copies the selected counter's value, as it stands before that clock edge, into that counter's snapshot register. A snapshot register changes at no other time. Reads of offsets 12 and 13 return bits 7:0 and 15:8 of the snapshot of the counter named by the most recent snapshot command.
- R7: A read of offset 14 returns bits 23:16 of counter 0's snapshot, even when the most recent snapshot was of counter 1.
- R8: With its enable high and no preload, a counter decrements by one per cycle and wraps from zero to all ones. With its enable low and no preload, it holds its value.
- R9: When a preload and that counter's enable fall in the same cycle, the preload wins.
- R10: Writes with the page select high, and writes to offsets other than 12 to 15, have no effect. Reads with the page select high, reads of offset 15, and reads of other offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_sel | input | 1 | Page select; this page responds when low |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, combinational from addr and page_sel |
| cnt_en | input | 2 | Per-counter decrement enable; bit 0 is counter 0 |

## Verification
Two pairs of events can land on one clock edge. The first is a preload command arriving while the target counter's enable is high. The second is a snapshot command arriving while that counter is still decrementing. The bench holds counter 0's enable high across a preload command and, on the next cycle, a snapshot command. It then expects the snapshot to show exactly the preloaded value, not that value minus one. A second snapshot taken after the enable drops must show the preloaded value minus one, which proves the decrement also happened on the snapshot cycle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_SNAP  = 2'b10,
    OP_SPARE = 2'b11
  } cmd_op_e;

  typedef struct packed {
    logic do_load;
    logic do_snap;
    logic target;
  } cmd_t;

  // Command byte layout: bit 0 = counter select, bits 2:1 = opcode.
  function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_t    c;
    cmd_op_e op;
    op        = cmd_op_e'(b[2:1]);
    c.target  = b[0];
    c.do_load = (op == OP_LOAD);
    c.do_snap = (op == OP_SNAP);
    return c;
  endfunction
endpackage

// File: rtl/dcs_regif.sv
module dcs_regif
  import dcs_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_OFF = 12,
  parameter int NUM_STG  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      page_sel,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr_en,
  input  logic [BYTE_W-1:0]         wr_data,
  output logic [NUM_STG*BYTE_W-1:0] stage,
  output logic [1:0]                load_str,
  output logic [1:0]                snap_str
);
  localparam int CMD_OFF = BASE_OFF + NUM_STG;

  logic page_wr;
  logic cmd_hit;
  cmd_t cmd;

  assign page_wr = wr_en && !page_sel;
  assign cmd_hit = page_wr && (addr == ADDR_W'(CMD_OFF));
  assign cmd     = decode_cmd(wr_data);

  for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
    logic byte_hit;
    assign byte_hit = page_wr && (addr == ADDR_W'(BASE_OFF + g));
    always_ff @(posedge clk) begin
      if (!rst_n)        stage[g*BYTE_W +: BYTE_W] <= '0;
      else if (byte_hit) stage[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_comb begin
    load_str = 2'b00;
    snap_str = 2'b00;
    if (cmd_hit) begin
      load_str[cmd.target] = cmd.do_load;
      snap_str[cmd.target] = cmd.do_snap;
    end
  end

  // R10: off-page writes leave staging untouched
  assert_page_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    page_sel |=> $stable(stage));
endmodule

// File: rtl/dcs_down.sv
module dcs_down #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] dec_wrap(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (en)   count <= dec_wrap(count);
  end

  // R4/R5 and R9: preload wins over enable
  assert_load_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  // R8: decrement with wrap
  assert_dec_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> count == $past(count) - W'(1));
  // R2: no change without preload or enable
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(count));
endmodule

// File: rtl/dcs_snap.sv
module dcs_snap
  import dcs_pkg::*;
#(
  parameter int W0       = 24,
  parameter int W1       = 16,
  parameter int ADDR_W   = 4,
  parameter int BASE_OFF = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        snap_str,
  input  logic [W0-1:0]     count0,
  input  logic [W1-1:0]     count1,
  input  logic              page_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int NB0 = W0 / BYTE_W;
  localparam int NB1 = W1 / BYTE_W;

  logic [W0-1:0] snap0;
  logic [W1-1:0] snap1;
  logic          last_sel;
  logic [W0-1:0] sel_bus;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap0    <= '0;
      snap1    <= '0;
      last_sel <= 1'b0;
    end else begin
      if (snap_str[0]) snap0 <= count0;
      if (snap_str[1]) snap1 <= count1;
      if (snap_str[0])      last_sel <= 1'b0;
      else if (snap_str[1]) last_sel <= 1'b1;
    end
  end

  assign sel_bus = last_sel ? W0'(snap1) : snap0;

  always_comb begin
    rd_data = '0;
    if (!page_sel) begin
      for (int k = 0; k < NB0; k++) begin
        if (addr == ADDR_W'(BASE_OFF + k)) begin
          if (k < NB1) rd_data = sel_bus[k*BYTE_W +: BYTE_W];
          else         rd_data = snap0[k*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  // R6: snapshot captures the pre-edge count, and holds otherwise
  assert_snap_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snap_str[0] |=> snap0 == $past(count0));
  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_str[1] |=> $stable(snap1));
endmodule

// File: rtl/dual_cnt_snap.sv
module dual_cnt_snap
  import dcs_pkg::*;
#(
  parameter int CNT0_W   = 24,
  parameter int CNT1_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int BASE_OFF = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [1:0]        cnt_en
);
  localparam int NUM_STG = CNT0_W / BYTE_W;

  logic [NUM_STG*BYTE_W-1:0] stage;
  logic [1:0]                load_str;
  logic [1:0]                snap_str;
  logic [CNT0_W-1:0]         cnt_bus [2];

  dcs_regif #(.ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF), .NUM_STG(NUM_STG)) u_regif (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .stage(stage),
    .load_str(load_str), .snap_str(snap_str)
  );

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    localparam int WI = (i == 0) ? CNT0_W : CNT1_W;
    logic [WI-1:0] cnt_w;
    dcs_down #(.W(WI)) u_down (
      .clk(clk), .rst_n(rst_n), .en(cnt_en[i]), .load(load_str[i]),
      .load_val(stage[WI-1:0]), .count(cnt_w)
    );
    assign cnt_bus[i] = CNT0_W'(cnt_w);
  end

  dcs_snap #(.W0(CNT0_W), .W1(CNT1_W), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_snap (
    .clk(clk), .rst_n(rst_n), .snap_str(snap_str),
    .count0(cnt_bus[0]), .count1(cnt_bus[1][CNT1_W-1:0]),
    .page_sel(page_sel), .addr(addr), .rd_data(rd_data)
  );

  // R3: one command strobe at most per write
  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (load_str == 2'b00 && snap_str == 2'b00));
endmodule

// File: tb/sim_dual_cnt_snap.sv
module sim_dual_cnt_snap;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       page_sel = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_en = 2'b00;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_cnt_snap u0 (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .cnt_en(cnt_en)
  );

  // vector: {kind(1=read,0=write), page, addr[3:0], data/expected[7:0], req[3:0]}
  localparam int NV = 38;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b0,4'd12,8'h00,4'd1},  // R1 reset read
    {1'b1,1'b0,4'd14,8'h00,4'd1},  // R1
    {1'b0,1'b0,4'd12,8'h11,4'd2},
    {1'b0,1'b0,4'd13,8'h22,4'd2},
    {1'b0,1'b0,4'd14,8'h33,4'd2},
    {1'b1,1'b0,4'd12,8'h00,4'd2},  // R2 staged not visible
    {1'b0,1'b0,4'd15,8'h04,4'd2},  // snapshot c0
    {1'b1,1'b0,4'd13,8'h00,4'd2},  // R2 counter unchanged
    {1'b0,1'b0,4'd15,8'h02,4'd4},  // preload c0
    {1'b0,1'b0,4'd15,8'h04,4'd4},
    {1'b1,1'b0,4'd12,8'h11,4'd4},  // R4
    {1'b1,1'b0,4'd13,8'h22,4'd4},
    {1'b1,1'b0,4'd14,8'h33,4'd4},
    {1'b0,1'b0,4'd14,8'h99,4'd5},
    {1'b0,1'b0,4'd15,8'h03,4'd5},  // preload c1
    {1'b0,1'b0,4'd15,8'h05,4'd5},  // snapshot c1
    {1'b1,1'b0,4'd12,8'h11,4'd6},  // R6
    {1'b1,1'b0,4'd13,8'h22,4'd5},  // R5 offset 14 ignored
    {1'b1,1'b0,4'd14,8'h33,4'd7},  // R7
    {1'b0,1'b0,4'd12,8'h55,4'd3},
    {1'b0,1'b0,4'd15,8'h00,4'd3},  // R3 no-op codes
    {1'b0,1'b0,4'd15,8'h07,4'd3},
    {1'b0,1'b0,4'd15,8'h06,4'd3},
    {1'b0,1'b0,4'd15,8'h01,4'd3},
    {1'b0,1'b0,4'd15,8'h04,4'd3},
    {1'b1,1'b0,4'd12,8'h11,4'd3},  // R3
    {1'b1,1'b0,4'd14,8'h33,4'd3},
    {1'b0,1'b1,4'd15,8'h02,4'd10}, // R10 off-page preload
    {1'b0,1'b1,4'd12,8'hEE,4'd10},
    {1'b0,1'b0,4'd15,8'h04,4'd10},
    {1'b1,1'b0,4'd14,8'h33,4'd10},
    {1'b1,1'b1,4'd14,8'h00,4'd10},
    {1'b1,1'b0,4'd15,8'h00,4'd10},
    {1'b0,1'b0,4'd11,8'hAA,4'd10},
    {1'b0,1'b0,4'd15,8'h03,4'd10},
    {1'b0,1'b0,4'd15,8'h05,4'd10},
    {1'b1,1'b0,4'd12,8'h55,4'd10},
    {1'b1,1'b0,4'd13,8'h22,4'd10}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic pg, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    page_sel = pg; addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; page_sel = 1'b0;
  endtask

  task automatic rd(input logic pg, input logic [3:0] a, input string req,
                    input logic [7:0] exp);
    @(negedge clk);
    page_sel = pg; addr = a;
    #1;
    check(req, rd_data, exp);
    page_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17])
        rd(VEC[i][16], VEC[i][15:12], $sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][11:4]);
      else
        wr(VEC[i][16], VEC[i][15:12], VEC[i][11:4]);
    end

    // R8: counter 1 from 0x0002, three enabled cycles wrap to 0xFFFF
    wr(1'b0, 4'd12, 8'h02);
    wr(1'b0, 4'd13, 8'h00);
    wr(1'b0, 4'd15, 8'h03);
    @(negedge clk); cnt_en = 2'b10;
    repeat (3) @(negedge clk);
    cnt_en = 2'b00;
    wr(1'b0, 4'd15, 8'h05);
    rd(1'b0, 4'd12, "R8 wrap low", 8'hFF);
    rd(1'b0, 4'd13, "R8 wrap high", 8'hFF);
    rd(1'b0, 4'd14, "R7 after c1 snapshot", 8'h33);

    // R9: preload with enable high, then snapshot with enable high
    wr(1'b0, 4'd12, 8'h10);
    wr(1'b0, 4'd13, 8'h00);
    wr(1'b0, 4'd14, 8'h00);
    @(negedge clk);
    cnt_en = 2'b01; addr = 4'd15; wr_data = 8'h02; wr_en = 1'b1;
    @(negedge clk);
    wr_data = 8'h04;
    @(negedge clk);
    wr_en = 1'b0; cnt_en = 2'b00;
    rd(1'b0, 4'd12, "R9 preload wins", 8'h10);
    rd(1'b0, 4'd14, "R9 upper", 8'h00);
    wr(1'b0, 4'd15, 8'h04);
    rd(1'b0, 4'd12, "R6 decrement on snapshot cycle", 8'h0F);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, 4'd12, "R1 post-reset low", 8'h00);
    rd(1'b0, 4'd13, "R1 post-reset mid", 8'h00);
    rd(1'b0, 4'd14, "R1 post-reset high", 8'h00);
    wr(1'b0, 4'd15, 8'h04);
    rd(1'b0, 4'd12, "R1 counter zero", 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule